// File: doc/BRIEF.md
# Multichannel Hold-Refresh Sequencer

This block keeps a bank of sample-and-hold channels topped up from a small code store. A scan pointer walks the store in ascending order. For each channel it reads the stored code, hands it to one shared DAC, lets the DAC settle and then pulses that channel's hold strobe. Each channel takes a fixed four-clock slot, so an undisturbed pass over the whole bank takes a fixed number of clocks.

A host writes new codes through a chip-select window. While the window is open, the scan freezes and no channel is refreshed. Every write strobe places a code at a channel address. When the window closes, the scan picks up again, and a resolved mode decides what happens first. In sequence mode the new code is only stored and goes out on the next normal visit. In immediate mode the slot that was already under way finishes, then one slot serves the written channel out of turn, and the scan continues from where it stopped. In burst mode several channels are loaded in one window, and the scan then leaves one empty slot before it carries on.

Top module: `chan_refresh_seq`

## Requirements
- R1: While `rst` is high, and after it, `dac_code` and `chan_sel` read 0, `hold_stb` is low and every stored code is 0. The first slot after reset serves channel 0, and its strobe is high in the third cycle after the first clock edge with `rst` low.
- R2: A slot lasts four clocks: read, DAC load, settle and strobe. `dac_code` and `chan_sel` change only at the end of the load clock. `hold_stb` is high for exactly one clock, the fourth. With no host activity, channels are served in ascending order and wrap from N_CH-1 to 0. A full pass is 4*N_CH clocks (128 by default).
- R3: While `cs_n` is low, the slot state freezes and `hold_stb` stays low. Each `wr_stb` writes `wr_code` to channel `wr_addr`. A `wr_stb` while `cs_n` is high is ignored: it changes no stored code.
- R4: The immediate request is `wr_imm_bit` OR `imm_pin`, and the burst request is `wr_burst_bit` OR `burst_pin`, both sampled with the write strobe. Immediate dominates burst. With neither, the write is in sequence mode.
- R5: Sequence mode: after `cs_n` rises the scan continues with no extra slot. The new code is seen on that channel's next normal visit.
- R6: Immediate mode: after `cs_n` rises, the slot already under way completes. Then one slot strobes the written channel with its new code. The scan then resumes at the first address whose slot had not begun. Interrupted between slots before channel k, the scan gives the written channel's strobe 4 plus the number of frozen clocks after the previous strobe, and channel k 4 clocks later.
- R7: Only the last write strobe of a window selects the mode and, in immediate mode, the serviced channel. Earlier writes in the window are stored only.
- R8: Burst mode: after `cs_n` rises, the slot under way completes, and one slot passes with no strobe. Normal scanning then resumes, so all N_CH channels are strobed within N_CH+1 slots.
- R9: A write to the channel whose slot has already passed its read clock does not change the code that slot loads and strobes. The new code appears on a later slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Host window, active low; freezes the scan |
| wr_stb | input | 1 | One-clock write strobe from the serial front end |
| wr_addr | input | ADDR_W | Channel address of the write |
| wr_code | input | CODE_W | Code to store |
| wr_imm_bit | input | 1 | Immediate request carried in the word |
| wr_burst_bit | input | 1 | Burst request carried in the word |
| imm_pin | input | 1 | External immediate request |
| burst_pin | input | 1 | External burst request |
| dac_code | output | CODE_W | Code presented to the shared DAC |
| chan_sel | output | ADDR_W | Channel the DAC code belongs to |
| hold_stb | output | 1 | One-clock hold strobe for `chan_sel` |

## Verification
A host window can open while a slot for some channel is halfway done, and a write to that same channel can then arrive. The completing refresh and the memory write would both act on that channel in overlapping time. The bench provokes this by dropping `cs_n` one clock after a slot has started and writing to that slot's channel. It judges the result by requiring that the finishing strobe still carries the old code and the next visit carries the new one. It also drops the window exactly on a slot boundary. There it checks strobe spacing counted in clocks, which tells a completed slot from a skipped or out-of-turn one.

// File: rtl/refseq_pkg.sv
package refseq_pkg;

    localparam int DEF_N_CH   = 32;
    localparam int DEF_CODE_W = 12;

    // Four phases of one channel slot, in execution order.
    typedef enum logic [1:0] {
        PH_READ   = 2'd0,
        PH_LOAD   = 2'd1,
        PH_SETTLE = 2'd2,
        PH_STROBE = 2'd3
    } slot_phase_e;

    // What a slot does with its channel.
    typedef enum logic [1:0] {
        SLOT_NORM = 2'd0,
        SLOT_IMM  = 2'd1,
        SLOT_SKIP = 2'd2
    } slot_kind_e;

    // Resolved write mode.
    typedef enum logic [1:0] {
        WM_SEQ   = 2'd0,
        WM_IMM   = 2'd1,
        WM_BURST = 2'd2
    } wr_mode_e;

    // Either source at logic 1 raises a request; immediate outranks burst.
    function automatic wr_mode_e resolve_mode(input logic imm_word, input logic imm_ext,
                                              input logic burst_word, input logic burst_ext);
        if (imm_word || imm_ext)
            return WM_IMM;
        else if (burst_word || burst_ext)
            return WM_BURST;
        else
            return WM_SEQ;
    endfunction

    function automatic slot_phase_e next_phase(input slot_phase_e ph);
        return slot_phase_e'(ph + 2'd1);
    endfunction

endpackage

// File: rtl/refseq_codemem.sv
module refseq_codemem #(
    parameter int N_CH   = refseq_pkg::DEF_N_CH,
    parameter int CODE_W = refseq_pkg::DEF_CODE_W,
    localparam int ADDR_W = $clog2(N_CH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [CODE_W-1:0] wdata,
    input  logic              re,
    input  logic [ADDR_W-1:0] raddr,
    output logic [CODE_W-1:0] rdata
);

    logic [CODE_W-1:0] store [N_CH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N_CH; i++)
                store[i] <= '0;
        end else if (we) begin
            store[waddr] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            rdata <= '0;
        else if (re)
            rdata <= store[raddr];
    end

    // Host writes and scan reads never share a cycle (R9 relies on it).
    assert_no_rw_clash_R9: assert property (@(posedge clk) disable iff (rst)
        !(we && re));

endmodule

// File: rtl/refseq_hostcap.sv
module refseq_hostcap #(
    parameter int N_CH   = refseq_pkg::DEF_N_CH,
    parameter int CODE_W = refseq_pkg::DEF_CODE_W,
    localparam int ADDR_W = $clog2(N_CH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic              wr_stb,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CODE_W-1:0] wr_code,
    input  logic              wr_imm_bit,
    input  logic              wr_burst_bit,
    input  logic              imm_pin,
    input  logic              burst_pin,
    input  logic              take,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_waddr,
    output logic [CODE_W-1:0] mem_wdata,
    output logic              pend_imm,
    output logic              pend_skip,
    output logic [ADDR_W-1:0] pend_addr
);
    import refseq_pkg::*;

    wr_mode_e wmode;
    logic     accept;

    assign accept    = wr_stb && !cs_n;
    assign wmode     = resolve_mode(wr_imm_bit, imm_pin, wr_burst_bit, burst_pin);
    assign mem_we    = accept;
    assign mem_waddr = wr_addr;
    assign mem_wdata = wr_code;

    // Each accepted strobe overwrites the pending request: last one wins.
    always_ff @(posedge clk) begin
        if (rst) begin
            pend_imm  <= 1'b0;
            pend_skip <= 1'b0;
            pend_addr <= '0;
        end else if (accept) begin
            pend_imm  <= (wmode == WM_IMM);
            pend_skip <= (wmode == WM_BURST);
            pend_addr <= wr_addr;
        end else if (take) begin
            pend_imm  <= 1'b0;
            pend_skip <= 1'b0;
        end
    end

    assert_imm_dominates_R4: assert property (@(posedge clk) disable iff (rst)
        (accept && (imm_pin || wr_imm_bit)) |=> (pend_imm && !pend_skip));

    assert_last_wins_R7: assert property (@(posedge clk) disable iff (rst)
        accept |=> (pend_addr == $past(wr_addr)));

    assert_pend_quiet_R3: assert property (@(posedge clk) disable iff (rst)
        (cs_n && !take) |=> ($stable(pend_imm) && $stable(pend_skip)));

endmodule

// File: rtl/refseq_slotctl.sv
module refseq_slotctl #(
    parameter int N_CH = refseq_pkg::DEF_N_CH,
    localparam int ADDR_W = $clog2(N_CH)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    run,
    input  logic                    pend_imm,
    input  logic                    pend_skip,
    input  logic [ADDR_W-1:0]       pend_addr,
    output logic                    take,
    output logic                    rd_en,
    output logic [ADDR_W-1:0]       rd_addr,
    output refseq_pkg::slot_phase_e phase,
    output refseq_pkg::slot_kind_e  cur_kind,
    output logic [ADDR_W-1:0]       cur_addr
);
    import refseq_pkg::*;

    logic [ADDR_W-1:0] ptr;
    logic [ADDR_W-1:0] ptr_inc;
    slot_kind_e        sel_kind;
    logic [ADDR_W-1:0] sel_addr;
    logic              slot_start;

    assign ptr_inc    = (ptr == ADDR_W'(N_CH - 1)) ? '0 : ptr + 1'b1;
    assign slot_start = run && (phase == PH_READ);

    // Choose the next slot: a pending immediate write goes first, then a
    // burst skip, otherwise the scan pointer.
    always_comb begin
        if (pend_imm) begin
            sel_kind = SLOT_IMM;
            sel_addr = pend_addr;
        end else if (pend_skip) begin
            sel_kind = SLOT_SKIP;
            sel_addr = ptr;
        end else begin
            sel_kind = SLOT_NORM;
            sel_addr = ptr;
        end
    end

    assign take    = slot_start;
    assign rd_en   = slot_start && (sel_kind != SLOT_SKIP);
    assign rd_addr = sel_addr;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase    <= PH_READ;
            ptr      <= '0;
            cur_kind <= SLOT_NORM;
            cur_addr <= '0;
        end else if (run) begin
            phase <= next_phase(phase);
            if (phase == PH_READ) begin
                cur_kind <= sel_kind;
                cur_addr <= sel_addr;
                if (sel_kind == SLOT_NORM)
                    ptr <= ptr_inc;
            end
        end
    end

    assert_freeze_R3: assert property (@(posedge clk) disable iff (rst)
        !run |=> ($stable(phase) && $stable(ptr)));

    assert_scan_order_R2: assert property (@(posedge clk) disable iff (rst)
        (slot_start && !pend_imm && !pend_skip) |=> (cur_addr == $past(ptr) && cur_kind == SLOT_NORM));

    assert_imm_resume_R6: assert property (@(posedge clk) disable iff (rst)
        (slot_start && pend_imm) |=> (cur_addr == $past(pend_addr) && $stable(ptr)));

    assert_skip_holds_ptr_R8: assert property (@(posedge clk) disable iff (rst)
        (slot_start && !pend_imm && pend_skip) |=> (cur_kind == SLOT_SKIP && $stable(ptr)));

endmodule

// File: rtl/refseq_dacout.sv
module refseq_dacout #(
    parameter int N_CH   = refseq_pkg::DEF_N_CH,
    parameter int CODE_W = refseq_pkg::DEF_CODE_W,
    localparam int ADDR_W = $clog2(N_CH)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    run,
    input  refseq_pkg::slot_phase_e phase,
    input  refseq_pkg::slot_kind_e  cur_kind,
    input  logic [ADDR_W-1:0]       cur_addr,
    input  logic [CODE_W-1:0]       rdata,
    output logic [CODE_W-1:0]       dac_code,
    output logic [ADDR_W-1:0]       chan_sel,
    output logic                    hold_stb
);
    import refseq_pkg::*;

    logic serving;
    logic load_now;

    assign serving  = (cur_kind != SLOT_SKIP);
    assign load_now = run && serving && (phase == PH_LOAD);

    always_ff @(posedge clk) begin
        if (rst) begin
            dac_code <= '0;
            chan_sel <= '0;
        end else if (load_now) begin
            dac_code <= rdata;
            chan_sel <= cur_addr;
        end
    end

    assign hold_stb = run && serving && (phase == PH_STROBE);

    assert_strobe_single_R2: assert property (@(posedge clk) disable iff (rst)
        hold_stb |=> !hold_stb);

    assert_strobe_needs_run_R3: assert property (@(posedge clk) disable iff (rst)
        hold_stb |-> run);

    assert_dac_steady_R9: assert property (@(posedge clk) disable iff (rst)
        hold_stb |-> ($stable(dac_code) && $stable(chan_sel)));

endmodule

// File: rtl/chan_refresh_seq.sv
module chan_refresh_seq #(
    parameter int N_CH   = refseq_pkg::DEF_N_CH,
    parameter int CODE_W = refseq_pkg::DEF_CODE_W,
    localparam int ADDR_W = $clog2(N_CH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic              wr_stb,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CODE_W-1:0] wr_code,
    input  logic              wr_imm_bit,
    input  logic              wr_burst_bit,
    input  logic              imm_pin,
    input  logic              burst_pin,
    output logic [CODE_W-1:0] dac_code,
    output logic [ADDR_W-1:0] chan_sel,
    output logic              hold_stb
);
    import refseq_pkg::*;

    logic              run;
    logic              mem_we;
    logic [ADDR_W-1:0] mem_waddr;
    logic [CODE_W-1:0] mem_wdata;
    logic              pend_imm;
    logic              pend_skip;
    logic [ADDR_W-1:0] pend_addr;
    logic              take;
    logic              rd_en;
    logic [ADDR_W-1:0] rd_addr;
    logic [CODE_W-1:0] rdata;
    slot_phase_e       phase;
    slot_kind_e        cur_kind;
    logic [ADDR_W-1:0] cur_addr;

    assign run = cs_n;

    refseq_hostcap #(.N_CH(N_CH), .CODE_W(CODE_W)) u_hostcap (
        .clk          (clk),
        .rst          (rst),
        .cs_n         (cs_n),
        .wr_stb       (wr_stb),
        .wr_addr      (wr_addr),
        .wr_code      (wr_code),
        .wr_imm_bit   (wr_imm_bit),
        .wr_burst_bit (wr_burst_bit),
        .imm_pin      (imm_pin),
        .burst_pin    (burst_pin),
        .take         (take),
        .mem_we       (mem_we),
        .mem_waddr    (mem_waddr),
        .mem_wdata    (mem_wdata),
        .pend_imm     (pend_imm),
        .pend_skip    (pend_skip),
        .pend_addr    (pend_addr)
    );

    refseq_codemem #(.N_CH(N_CH), .CODE_W(CODE_W)) u_codemem (
        .clk   (clk),
        .rst   (rst),
        .we    (mem_we),
        .waddr (mem_waddr),
        .wdata (mem_wdata),
        .re    (rd_en),
        .raddr (rd_addr),
        .rdata (rdata)
    );

    refseq_slotctl #(.N_CH(N_CH)) u_slotctl (
        .clk       (clk),
        .rst       (rst),
        .run       (run),
        .pend_imm  (pend_imm),
        .pend_skip (pend_skip),
        .pend_addr (pend_addr),
        .take      (take),
        .rd_en     (rd_en),
        .rd_addr   (rd_addr),
        .phase     (phase),
        .cur_kind  (cur_kind),
        .cur_addr  (cur_addr)
    );

    refseq_dacout #(.N_CH(N_CH), .CODE_W(CODE_W)) u_dacout (
        .clk      (clk),
        .rst      (rst),
        .run      (run),
        .phase    (phase),
        .cur_kind (cur_kind),
        .cur_addr (cur_addr),
        .rdata    (rdata),
        .dac_code (dac_code),
        .chan_sel (chan_sel),
        .hold_stb (hold_stb)
    );

endmodule

// File: tb/chan_refresh_seq_bench.sv
module chan_refresh_seq_bench;

    localparam int NCH = 32;
    localparam int CW  = 12;
    localparam int AW  = 5;
    localparam int MAXEV = 1024;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cs_n = 1'b1;
    logic          wr_stb = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [CW-1:0] wr_code = '0;
    logic          wr_imm_bit = 1'b0;
    logic          wr_burst_bit = 1'b0;
    logic          imm_pin = 1'b0;
    logic          burst_pin = 1'b0;
    logic [CW-1:0] dac_code;
    logic [AW-1:0] chan_sel;
    logic          hold_stb;

    chan_refresh_seq u_chan_refresh_seq (
        .clk(clk), .rst(rst), .cs_n(cs_n), .wr_stb(wr_stb), .wr_addr(wr_addr),
        .wr_code(wr_code), .wr_imm_bit(wr_imm_bit), .wr_burst_bit(wr_burst_bit),
        .imm_pin(imm_pin), .burst_pin(burst_pin),
        .dac_code(dac_code), .chan_sel(chan_sel), .hold_stb(hold_stb)
    );

    always #4 clk = ~clk;   // 125 MHz

    int vectors = 0;
    int miscompares = 0;
    int cyc = 0;
    int bad_stb = 0;
    int ev_n = 0;
    int ev_ch [MAXEV];
    int ev_code [MAXEV];
    int ev_cyc [MAXEV];
    int model [NCH];
    bit finished = 0;

    always @(posedge clk) cyc <= cyc + 1;

    // Strobe log, sampled 1 ns after the falling edge.
    always begin
        @(negedge clk);
        #1;
        if (!rst && hold_stb) begin
            if (!cs_n) bad_stb++;
            if (ev_n < MAXEV) begin
                ev_ch[ev_n]   = int'(chan_sel);
                ev_code[ev_n] = int'(dac_code);
                ev_cyc[ev_n]  = cyc;
            end
            ev_n++;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    endtask

    // Wait until a new strobe for channel ch has been logged; returns its index.
    task automatic wait_strobe(input int ch, output int idx);
        int n0 = ev_n;
        forever begin
            @(negedge clk);
            #2;
            if (ev_n > n0 && ev_ch[ev_n-1] == ch) break;
        end
        idx = ev_n - 1;
    endtask

    task automatic wait_events(input int target);
        while (ev_n < target) begin
            @(negedge clk);
            #2;
        end
    endtask

    // Opens the window on a slot boundary (mid=0) or one clock into a slot (mid=1).
    task automatic open_win(input bit mid, output int t_lo);
        @(negedge clk);
        if (mid) @(negedge clk);
        cs_n = 1'b0;
        t_lo = cyc;
    endtask

    task automatic close_win(input int t_lo, output int frozen);
        @(negedge clk);
        cs_n = 1'b1;
        frozen = cyc - t_lo;
    endtask

    task automatic host_wr(input int a, input int code, input bit ib, input bit bb,
                           input bit ip, input bit bp);
        @(negedge clk);
        wr_stb = 1'b1;  wr_addr = AW'(a);  wr_code = CW'(code);
        wr_imm_bit = ib; wr_burst_bit = bb; imm_pin = ip; burst_pin = bp;
        if (!cs_n) model[a] = code;
        @(negedge clk);
        wr_stb = 1'b0; wr_imm_bit = 1'b0; wr_burst_bit = 1'b0;
        imm_pin = 1'b0; burst_pin = 1'b0;
    endtask

    task automatic exp_ev(input int i, input int ch, input int code, input string tag);
        wait_events(i + 1);
        check(ev_ch[i] == ch, {tag, " channel"}, ev_ch[i], ch);
        check(ev_code[i] == code, {tag, " code"}, ev_code[i], code);
    endtask

    task automatic exp_gap(input int i, input int gap, input string tag);
        wait_events(i + 1);
        check(ev_cyc[i] - ev_cyc[i-1] == gap, {tag, " spacing"}, ev_cyc[i] - ev_cyc[i-1], gap);
    endtask

    task automatic t_reset();
        int rel;
        repeat (3) @(negedge clk);
        check(dac_code == '0, "R1 dac_code in reset", int'(dac_code), 0);
        check(chan_sel == '0, "R1 chan_sel in reset", int'(chan_sel), 0);
        check(hold_stb == 1'b0, "R1 hold_stb in reset", int'(hold_stb), 0);
        rst = 1'b0;
        rel = cyc;
        exp_ev(0, 0, 0, "R1 first slot");
        check(ev_cyc[0] - rel == 3, "R1 first strobe cycle", ev_cyc[0] - rel, 3);
    endtask

    task automatic t_scan();
        int err_ord = 0, err_gap = 0, err_code = 0;
        int i9;
        // Strobe with cs_n high: must be ignored (R3).
        host_wr(9, 'h999, 1'b1, 1'b0, 1'b0, 1'b0);
        wait_events(33);
        for (int i = 1; i <= 32; i++) begin
            if (ev_ch[i] != (i % NCH)) err_ord++;
            if (ev_cyc[i] - ev_cyc[i-1] != 4) err_gap++;
            if (ev_code[i] != 0) err_code++;
        end
        check(err_ord == 0, "R2 ascending wrap order", err_ord, 0);
        check(err_gap == 0, "R2 four-clock slot", err_gap, 0);
        check(ev_cyc[32] - ev_cyc[0] == 128, "R2 full pass clocks", ev_cyc[32] - ev_cyc[0], 128);
        check(err_code == 0, "R3 write with cs_n high ignored", err_code, 0);
        wait_strobe(9, i9);
        check(ev_code[i9] == 0, "R3 ignored write ch9", ev_code[i9], 0);
    endtask

    task automatic t_seq_write();
        int k, tl, fz;
        wait_strobe(2, k);
        open_win(1'b0, tl);
        host_wr(5, 'hABC, 1'b0, 1'b0, 1'b0, 1'b0);
        repeat (3) @(negedge clk);
        close_win(tl, fz);
        exp_ev(k + 1, 3, model[3], "R5 resume ch3");
        exp_gap(k + 1, 4 + fz, "R5 no extra slot");
        exp_ev(k + 3, 5, 'hABC, "R5 stored code on visit");
        check(bad_stb == 0, "R3 no strobe while cs_n low", bad_stb, 0);
    endtask

    task automatic t_imm_midslot();
        int k, tl, fz;
        wait_strobe(6, k);
        open_win(1'b1, tl);
        host_wr(20, 'h520, 1'b0, 1'b0, 1'b1, 1'b0);
        repeat (4) @(negedge clk);
        close_win(tl, fz);
        exp_ev(k + 1, 7, model[7], "R6 in-progress slot completes");
        exp_ev(k + 2, 20, 'h520, "R6 out-of-turn slot");
        exp_gap(k + 2, 4, "R6 out-of-turn timing");
        exp_ev(k + 3, 8, model[8], "R6 resume after ch7");
        exp_gap(k + 3, 4, "R6 resume timing");
    endtask

    task automatic t_same_chan();
        int k, tl, fz, j;
        wait_strobe(13, k);
        open_win(1'b1, tl);
        host_wr(14, 'h0EE, 1'b0, 1'b0, 1'b0, 1'b0);
        close_win(tl, fz);
        exp_ev(k + 1, 14, 0, "R9 in-flight slot keeps old code");
        exp_ev(k + 2, 15, model[15], "R9 scan continues");
        wait_strobe(14, j);
        check(ev_code[j] == 'h0EE, "R9 new code on next visit", ev_code[j], 'h0EE);
    endtask

    task automatic t_imm_boundary();
        int k, tl, fz;
        wait_strobe(10, k);
        open_win(1'b0, tl);
        host_wr(7, 'h777, 1'b1, 1'b0, 1'b0, 1'b0);
        close_win(tl, fz);
        exp_ev(k + 1, 7, 'h777, "R6 boundary immediate");
        exp_gap(k + 1, 4 + fz, "R6 boundary immediate timing");
        exp_ev(k + 2, 11, model[11], "R6 resume at unstarted ch11");
        exp_gap(k + 2, 4, "R6 resume timing");
    endtask

    task automatic t_last_wins();
        int k, tl, fz;
        wait_strobe(22, k);
        open_win(1'b0, tl);
        host_wr(25, 'h250, 1'b1, 1'b0, 1'b0, 1'b0);
        host_wr(26, 'h260, 1'b0, 1'b0, 1'b0, 1'b0);
        close_win(tl, fz);
        exp_ev(k + 1, 23, model[23], "R7 seq last: no out-of-turn");
        exp_ev(k + 3, 25, 'h250, "R7 earlier imm only stored");
        exp_ev(k + 4, 26, 'h260, "R7 seq write stored");
        wait_strobe(27, k);
        open_win(1'b0, tl);
        host_wr(28, 'h280, 1'b0, 1'b0, 1'b0, 1'b0);
        host_wr(29, 'h290, 1'b1, 1'b0, 1'b0, 1'b0);
        close_win(tl, fz);
        exp_ev(k + 1, 29, 'h290, "R7 last imm selects channel");
        exp_ev(k + 2, 28, 'h280, "R7 resume ch28");
    endtask

    task automatic t_burst();
        int k, tl, fz, miss;
        bit seen [NCH];
        wait_strobe(3, k);
        open_win(1'b0, tl);
        host_wr(1, 'h101, 1'b0, 1'b0, 1'b0, 1'b1);
        host_wr(2, 'h202, 1'b0, 1'b1, 1'b0, 1'b0);
        host_wr(3, 'h303, 1'b0, 1'b1, 1'b0, 1'b0);
        close_win(tl, fz);
        exp_ev(k + 1, 4, model[4], "R8 resume after skip");
        exp_gap(k + 1, 8 + fz, "R8 one skipped slot");
        wait_events(k + 33);
        miss = 0;
        for (int c = 0; c < NCH; c++) seen[c] = 1'b0;
        for (int i = k + 1; i <= k + 32; i++) begin
            seen[ev_ch[i]] = 1'b1;
            if (ev_code[i] != model[ev_ch[i]]) miss++;
        end
        for (int c = 0; c < NCH; c++) if (!seen[c]) miss++;
        check(miss == 0, "R8 all channels refreshed with codes", miss, 0);
        check(ev_cyc[k + 32] - ev_cyc[k] == 132 + fz, "R8 33 slots for full refresh",
              ev_cyc[k + 32] - ev_cyc[k], 132 + fz);
    endtask

    task automatic t_dominance();
        int k, tl, fz;
        wait_strobe(15, k);
        open_win(1'b0, tl);
        host_wr(30, 'h3A0, 1'b0, 1'b1, 1'b1, 1'b0);
        close_win(tl, fz);
        exp_ev(k + 1, 30, 'h3A0, "R4 imm pin beats burst bit");
        exp_gap(k + 1, 4 + fz, "R4 no skip slot");
        exp_ev(k + 2, 16, model[16], "R4 resume ch16");
        exp_gap(k + 2, 4, "R4 resume timing");
    endtask

    initial begin
        for (int c = 0; c < NCH; c++) model[c] = 0;
        t_reset();
        t_scan();
        t_seq_write();
        t_imm_midslot();
        t_same_chan();
        t_imm_boundary();
        t_last_wins();
        t_burst();
        t_dominance();
        check(bad_stb == 0, "R3 strobe never seen with cs_n low", bad_stb, 0);
        finished = 1;
        summary();
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            vectors++;
            miscompares++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
            summary();
            $finish;
        end
    end

endmodule